// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block derives a peripheral clock from its parent clock. Software places a divisor code in a register and sets a single gate bit; the block then produces a divided clock whose period is a whole number of parent cycles. Two field variants are offered through a parameter. The narrow variant holds a 5-bit ratio code. The wide variant adds a sixth bit that switches in a fixed prescaler of 64, for slow clocks such as a storage-card interface.

A new divisor never changes the output in the middle of a period. The code is accepted at once, a busy flag rises, and the new ratio is loaded at the next output period boundary, where busy falls again. Software is expected to poll busy before and after each divisor write. Disabling the gate lets the current high phase finish and parks the output low. Enabling it starts the output at a period boundary with a full high phase.

Top module: `gated_clk_div`

## Requirements
- R1: After reset the divisor code reads 0, the gate bit reads 0, busy is 0, the status register reads 0, address 3 reads 0 and clk_out stays low.
- R2: Narrow variant (5-bit code): a code k in 2..31 divides by k, code 0 divides by 32, and code 1 divides by 2, the smallest ratio a registered output can give.
- R3: Wide variant (6-bit code): with bit 5 clear the code in bits 4:0 divides as in R2 but code 0 divides by 64; with bit 5 set the ratio is 64 times bits 4:0, and 0x20 divides by 64.
- R4: For a ratio N, clk_out is high for floor(N/2) parent cycles and low for the remaining N - floor(N/2) cycles.
- R5: A divisor write (address 0) whose data has any bit set above the code field is dropped: the stored code is unchanged and busy does not rise.
- R6: An accepted divisor write raises busy on the next parent cycle, seen both on the busy port and as bits 4 and 3 of the status register (address 2, value 0x18); busy falls at the next output period boundary, and the following output period uses the new ratio.
- R7: A divisor write while busy is 1 is ignored; the code read back and the ratio in effect are those of the earlier write.
- R8: The gate bit is bit 0 of address 1 and reads back as written; clearing it never shortens a high phase already begun, and after that period clk_out stays low.
- R9: Setting the gate bit starts clk_out at the next period boundary, within N + 1 parent cycles, and the first high phase is full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 divisor, 1 gate, 2 status, 3 spare |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| busy | output | 1 | High while an accepted divisor waits for a period boundary |
| clk_out | output | 1 | Gated divided clock |

## Verification
The bench drives both variants and measures each high and low phase in parent cycles, so a wrong zero-code decode shows up as a 32 or 64 ratio off by the prescale, and a wrong odd-ratio split shows up as a swapped or equal duty. It clears the gate one cycle into a high phase, where a design that gated combinationally would cut a runt pulse, and it writes a second divisor while busy, where a design that took the write would load the wrong ratio. Out-of-range codes are written to catch a design that truncates instead of rejecting, and the status register is read to catch busy missing from either bit.

// File: rtl/gcd_pkg.sv
// Shared register map and field positions for the gated clock divider.
// Assumes a 2-bit register address space.
package gcd_pkg;
    typedef enum logic [1:0] {
        SEL_DIV   = 2'd0,
        SEL_GATE  = 2'd1,
        SEL_STAT  = 2'd2,
        SEL_SPARE = 2'd3
    } reg_sel_e;

    localparam int BUSY_LSB = 3;
    localparam int BUSY_MSB = 4;
endpackage

// File: rtl/gcd_regs.sv
// Register file of the divider: divisor code, gate bit and busy flag.
// Assumes DW > FW. A divisor write is taken only when its data fits the
// field and no earlier write is still pending; busy clears on apply.
module gcd_regs #(
    parameter int DW = 8,
    parameter int FW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [1:0]    rd_addr,
    input  logic          apply,
    output logic [DW-1:0] rd_data,
    output logic [FW-1:0] div_code,
    output logic          gate_on,
    output logic          busy
);
    import gcd_pkg::*;

    logic [FW-1:0] div_code_q;
    logic          gate_q;
    logic          busy_q;
    logic          over_range;
    logic          div_wr;
    logic          div_take;
    logic          gate_wr;
    reg_sel_e      wsel;
    reg_sel_e      rsel;

    assign wsel       = reg_sel_e'(wr_addr);
    assign rsel       = reg_sel_e'(rd_addr);
    assign over_range = |wr_data[DW-1:FW];
    assign div_wr     = wr_en && (wsel == SEL_DIV);
    assign div_take   = div_wr && !over_range && !busy_q;
    assign gate_wr    = wr_en && (wsel == SEL_GATE);

    // Hold the accepted divisor code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_code_q <= '0;
        end else if (div_take) begin
            div_code_q <= wr_data[FW-1:0];
        end
    end

    // Raise busy on an accepted write, drop it when the boundary loads it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (div_take) begin
            busy_q <= 1'b1;
        end else if (apply) begin
            busy_q <= 1'b0;
        end
    end

    // Hold the gate bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else if (gate_wr) begin
            gate_q <= wr_data[0];
        end
    end

    // Select read data by address.
    always_comb begin
        rd_data = '0;
        case (rsel)
            SEL_DIV:  rd_data[FW-1:0] = div_code_q;
            SEL_GATE: rd_data[0] = gate_q;
            SEL_STAT: rd_data[BUSY_MSB:BUSY_LSB] = {2{busy_q}};
            default:  rd_data = '0;
        endcase
    end

    assign div_code = div_code_q;
    assign gate_on  = gate_q;
    assign busy     = busy_q;

    // R5
    reject_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_wr && over_range && !busy_q) |=> ($stable(div_code_q) && !$rose(busy_q)));

    // R6
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(wr_en && (wsel == SEL_DIV)));

    // R6
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> $past(apply));

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && div_wr) |=> $stable(div_code_q));
endmodule

// File: rtl/gcd_ratio_dec.sv
// Turns a divisor code into a ratio and its high and low phase lengths.
// Assumes CW can hold the largest ratio. The wide variant reads the top
// code bit as a prescale select; the narrow variant takes the code as is.
module gcd_ratio_dec #(
    parameter int LOW_W     = 5,
    parameter int WIDE      = 0,
    parameter int PRE_SHIFT = 6,
    parameter int FW        = 5,
    parameter int CW        = 6
) (
    input  logic [FW-1:0] code,
    output logic [CW-1:0] ratio,
    output logic [CW-1:0] hi_len,
    output logic [CW-1:0] lo_len
);
    localparam logic [CW-1:0] FULL_RATIO = CW'(1) << FW;
    localparam logic [CW-1:0] MIN_RATIO  = CW'(2);

    logic [CW-1:0] raw;

    generate
        if (WIDE != 0) begin : g_wide
            logic [CW-1:0] low_ext;
            assign low_ext = CW'(code[LOW_W-1:0]);
            assign raw = code[FW-1] ? (low_ext << PRE_SHIFT) : CW'(code);
        end else begin : g_plain
            assign raw = CW'(code);
        end
    endgenerate

    // Map zero to the full ratio and clamp the ratio to the minimum.
    always_comb begin
        if (raw == '0) begin
            ratio = FULL_RATIO;
        end else if (raw == CW'(1)) begin
            ratio = MIN_RATIO;
        end else begin
            ratio = raw;
        end
        hi_len = ratio >> 1;
        lo_len = ratio - hi_len;
    end
endmodule

// File: rtl/gcd_phase_gen.sv
// Produces the divided clock as a registered phase bit with a phase counter.
// Assumes hi_len, lo_len and ratio are at least 1. New lengths and the gate
// are sampled only at the end of a low phase, so no runt pulse can occur.
module gcd_phase_gen #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gate_on,
    input  logic [CW-1:0] ratio,
    input  logic [CW-1:0] hi_len,
    input  logic [CW-1:0] lo_len,
    output logic          clk_out,
    output logic          boundary
);
    logic          phase_q;
    logic [CW-1:0] left_q;
    logic [CW-1:0] lo_keep_q;
    logic          last;

    assign last     = (left_q == CW'(1));
    assign boundary = last && !phase_q;

    // Step the phase counter and switch phase on its last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= 1'b0;
            left_q    <= CW'(1);
            lo_keep_q <= CW'(1);
        end else if (last) begin
            if (phase_q) begin
                phase_q <= 1'b0;
                left_q  <= lo_keep_q;
            end else if (gate_on) begin
                phase_q   <= 1'b1;
                left_q    <= hi_len;
                lo_keep_q <= lo_len;
            end else begin
                left_q <= ratio;
            end
        end else begin
            left_q <= left_q - CW'(1);
        end
    end

    assign clk_out = phase_q;

    // R8
    gate_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_q && !gate_on) |=> !phase_q);

    // R9
    start_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_q) |-> ($past(boundary) && $past(gate_on)));

    // R4
    fall_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phase_q) |-> $past(last));
endmodule

// File: rtl/gated_clk_div.sv
// Top of the gated programmable clock divider.
// Assumes a single parent clock and synchronous active-low reset. WIDE
// selects the 6-bit code with a prescale bit; widths derive from parameters.
module gated_clk_div #(
    parameter int DATA_W    = 8,
    parameter int LOW_W     = 5,
    parameter int WIDE      = 0,
    parameter int PRE_SHIFT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              clk_out
);
    localparam int FW        = LOW_W + ((WIDE != 0) ? 1 : 0);
    localparam int PRE_MAX   = (WIDE != 0) ? (((1 << LOW_W) - 1) << PRE_SHIFT) : 0;
    localparam int MAX_RATIO = (PRE_MAX > (1 << FW)) ? PRE_MAX : (1 << FW);
    localparam int CW        = $clog2(MAX_RATIO + 1);

    logic [FW-1:0] div_code;
    logic          gate_on;
    logic          boundary;
    logic [CW-1:0] ratio;
    logic [CW-1:0] hi_len;
    logic [CW-1:0] lo_len;

    gcd_regs #(
        .DW (DATA_W),
        .FW (FW)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .apply    (boundary),
        .rd_data  (rd_data),
        .div_code (div_code),
        .gate_on  (gate_on),
        .busy     (busy)
    );

    gcd_ratio_dec #(
        .LOW_W     (LOW_W),
        .WIDE      (WIDE),
        .PRE_SHIFT (PRE_SHIFT),
        .FW        (FW),
        .CW        (CW)
    ) i_ratio (
        .code   (div_code),
        .ratio  (ratio),
        .hi_len (hi_len),
        .lo_len (lo_len)
    );

    gcd_phase_gen #(
        .CW (CW)
    ) i_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_on  (gate_on),
        .ratio    (ratio),
        .hi_len   (hi_len),
        .lo_len   (lo_len),
        .clk_out  (clk_out),
        .boundary (boundary)
    );
endmodule

// File: tb/test_gated_clk_div.sv
// Directed bench for both code variants of the gated clock divider.
module test_gated_clk_div;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en_n = 1'b0;
    logic       wr_en_w = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data_n, rd_data_w;
    logic       busy_n, busy_w, clk_out_n, clk_out_w;
    int         checks = 0;
    int         failures = 0;

    always #(CLK_P/2) clk = ~clk;

    gated_clk_div i_gated_clk_div (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_n), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data_n),
        .busy(busy_n), .clk_out(clk_out_n)
    );

    gated_clk_div #(.WIDE(1)) i_gated_clk_div_w (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_w), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data_w),
        .busy(busy_w), .clk_out(clk_out_w)
    );

    function automatic logic outv(bit w);
        return w ? clk_out_w : clk_out_n;
    endfunction

    function automatic logic busyv(bit w);
        return w ? busy_w : busy_n;
    endfunction

    function automatic int exp_ratio(bit w, int code);
        int r;
        if (w && code[5]) r = (code & 31) * 64;
        else r = code;
        if (r == 0) r = w ? 64 : 32;
        if (r == 1) r = 2;
        return r;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_reg(bit w, int addr, int data);
        wr_addr = 2'(addr);
        wr_data = 8'(data);
        if (w) wr_en_w = 1'b1; else wr_en_n = 1'b1;
        @(negedge clk);
        wr_en_w = 1'b0;
        wr_en_n = 1'b0;
    endtask

    task automatic read_reg(bit w, int addr, output int d);
        rd_addr = 2'(addr);
        #1;
        d = w ? int'(rd_data_w) : int'(rd_data_n);
    endtask

    task automatic wait_busy_low(bit w, output int cyc);
        cyc = 0;
        while (busyv(w) && cyc < 4200) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic wait_rise(bit w);
        int t = 0;
        while (outv(w) !== 1'b0 && t < 5000) begin @(negedge clk); t++; end
        while (outv(w) !== 1'b1 && t < 5000) begin @(negedge clk); t++; end
    endtask

    task automatic measure(bit w, output int hi, output int lo);
        int t = 0;
        wait_rise(w);
        hi = 0;
        while (outv(w) === 1'b1 && t < 5000) begin hi++; @(negedge clk); t++; end
        lo = 0;
        while (outv(w) === 1'b0 && t < 5000) begin lo++; @(negedge clk); t++; end
    endtask

    // R1: reset values of every register and the output.
    task automatic t_reset();
        int d;
        int highs = 0;
        for (int w = 0; w < 2; w++) begin
            read_reg(bit'(w), 0, d); check("R1", "divisor after reset", d, 0);
            read_reg(bit'(w), 1, d); check("R1", "gate after reset", d, 0);
            read_reg(bit'(w), 2, d); check("R1", "status after reset", d, 0);
            read_reg(bit'(w), 3, d); check("R1", "spare after reset", d, 0);
            check("R1", "busy after reset", int'(busyv(bit'(w))), 0);
        end
        for (int i = 0; i < 80; i++) begin
            if (clk_out_n || clk_out_w) highs++;
            @(negedge clk);
        end
        check("R1", "clk_out high samples while gated", highs, 0);
    endtask

    // R2/R3/R4/R6: program a code, follow busy, measure both phases.
    task automatic t_ratio(bit w, int code, string req);
        int d, cyc, hi, lo, r;
        r = exp_ratio(w, code);
        write_reg(w, 0, code);
        check("R6", "busy after write", int'(busyv(w)), 1);
        read_reg(w, 2, d); check("R6", "status busy bits", d, 8'h18);
        read_reg(w, 0, d); check(req, "code readback", d, code);
        wait_busy_low(w, cyc);
        check("R6", "busy cleared in time", int'(cyc < 4200), 1);
        measure(w, hi, lo);
        check(req, $sformatf("high phase code 0x%0h", code), hi, r / 2);
        check("R4", $sformatf("low phase code 0x%0h", code), lo, r - r / 2);
    endtask

    // R5: codes with bits above the field are dropped.
    task automatic t_reject(bit w, int bad, int keep);
        int d;
        write_reg(w, 0, bad);
        check("R5", "busy after rejected write", int'(busyv(w)), 0);
        read_reg(w, 0, d); check("R5", "code after rejected write", d, keep);
    endtask

    // R7: a second write during busy does not replace the first.
    task automatic t_busy_ignore();
        int d, cyc, hi, lo;
        wait_rise(1'b0);
        write_reg(1'b0, 0, 6);
        write_reg(1'b0, 0, 10);
        check("R7", "busy held after ignored write", int'(busy_n), 1);
        read_reg(1'b0, 0, d); check("R7", "code keeps first write", d, 6);
        wait_busy_low(1'b0, cyc);
        measure(1'b0, hi, lo);
        check("R7", "high phase of first code", hi, 3);
        check("R7", "low phase of first code", lo, 3);
    endtask

    // R8: clearing the gate in a high phase keeps that phase whole.
    task automatic t_gate_off();
        int d, hi, highs;
        wait_rise(1'b0);
        hi = 1;
        write_reg(1'b0, 1, 0);
        while (clk_out_n === 1'b1 && hi < 100) begin hi++; @(negedge clk); end
        check("R8", "high phase length at gate off", hi, 4);
        read_reg(1'b0, 1, d); check("R8", "gate readback", d, 0);
        highs = 0;
        for (int i = 0; i < 40; i++) begin
            if (clk_out_n) highs++;
            @(negedge clk);
        end
        check("R8", "high samples after gate off", highs, 0);
    endtask

    // R9: setting the gate starts a full high phase within one period.
    task automatic t_gate_on();
        int d, cyc, hi;
        write_reg(1'b0, 1, 1);
        read_reg(1'b0, 1, d); check("R9", "gate readback", d, 1);
        cyc = 0;
        while (clk_out_n !== 1'b1 && cyc < 100) begin @(negedge clk); cyc++; end
        check("R9", "start within one period", int'(cyc <= 9), 1);
        hi = 0;
        while (clk_out_n === 1'b1 && hi < 100) begin hi++; @(negedge clk); end
        check("R9", "first high phase full", hi, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        write_reg(1'b0, 1, 1);
        write_reg(1'b1, 1, 1);
        t_ratio(1'b0, 0, "R2");
        t_ratio(1'b0, 1, "R2");
        t_ratio(1'b0, 5, "R2");
        t_ratio(1'b0, 31, "R2");
        t_ratio(1'b0, 8, "R2");
        t_reject(1'b0, 8'h25, 8);
        t_busy_ignore();
        t_ratio(1'b0, 8, "R2");
        t_gate_off();
        t_gate_on();
        t_ratio(1'b1, 8'h03, "R3");
        t_ratio(1'b1, 8'h00, "R3");
        t_ratio(1'b1, 8'h20, "R3");
        t_ratio(1'b1, 8'h22, "R3");
        t_ratio(1'b1, 8'h21, "R3");
        t_reject(1'b1, 8'h45, 8'h21);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        failures++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule